// File: doc/BRIEF.md
# Half-bridge gate drive controller

This block sequences the two switches of a synchronous buck half bridge. A PWM level, already classified by two comparator flags into high, low or mid-window, becomes a pair of gate enables that are never high together. A dead time separates any turn-off from the following turn-on. That dead time adapts: it becomes one cycle shorter after each gap in which the low-side body diode was seen conducting, and one cycle longer after each gap in which it was not. It stays between two parameter limits.

Several conditions override the PWM input. A mid-window PWM level that persists for a qualifying delay turns both switches off. Undervoltage, a latched over-temperature trip and an external disable request all force both gates low in the same clock cycle. The high side is also held off until the bootstrap supply is ready, and that readiness has hysteresis. The block drives four status outputs: power ready, the internal enable line, the auxiliary regulator enable and the gate regulator enable. After any shutdown, the block restarts with both switches off and waits one full maximum dead time before turning either switch on.

Top module: `hb_gate_ctrl`

## Requirements
- R1: While reset is asserted, and with all inputs low after reset, every output is 0.
- R2: A qualified high level (pwm_above_hi=1) selects the high side: gate_hs=1 and gate_ls=0. A qualified low level (pwm_above_hi=0, pwm_below_lo=1) selects the low side: gate_ls=1 and gate_hs=0. gate_hs and gate_ls are never 1 in the same cycle.
- R3: Every change of the conducting side passes through a gap. In that gap both gates stay 0 for exactly the current dead-time value, in clock cycles.
- R4: At the end of each gap, the dead time for the next gap is updated. If diode_cond was 1 on any sampled cycle of the gap, the dead time drops by 1, but not below DT_MIN. Otherwise it rises by 1, but not above DT_MAX.
- R5: Mid level means pwm_above_hi=0 and pwm_below_lo=0. When TRI_DLY consecutive samples are mid, both gates turn off one edge after the last of those samples. A shorter mid run has no effect on the gates.
- R6: After a mid-level shutdown, switching resumes only after TRI_DLY consecutive samples outside the mid window. A shorter valid run followed by mid again keeps both gates off.
- R7: Any of supply_ok=0, dis_n=0 or ot_trip=1 sampled at a clock edge makes both gates 0 from that edge on.
- R8: While supply_ok=0, pwr_ready, en_drive, aux_reg_en and gate_reg_en are 0. Over-temperature inputs are ignored, so a trip seen during undervoltage is not retained.
- R9: With supply_ok=1, an ot_trip sample sets a latch that holds both gates off and drives gate_reg_en to 0. The latch clears only on an ot_clear sample taken while ot_trip=0. If ot_trip and ot_clear are sampled together, the trip wins.
- R10: dis_n=0 drives en_drive and aux_reg_en to 0 and leaves pwr_ready unchanged. aux_reg_en is 1 only when pwr_ready and en_drive are both 1.
- R11: When the run condition returns, the dead time is reset to DT_MAX. Both gates then stay 0 for DT_MAX cycles before the selected side turns on.
- R12: boot_above_on=1 makes the bootstrap ready. boot_below_off=1 with boot_above_on=0 makes it not ready. With both flags at 0, the previous state is held. gate_hs is 1 only while the bootstrap is ready, and it drops on the edge that samples the not-ready condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_above_hi | input | 1 | PWM level is above the high threshold |
| pwm_below_lo | input | 1 | PWM level is below the low threshold |
| supply_ok | input | 1 | Control supply is above the undervoltage level |
| ot_trip | input | 1 | Die temperature is above the trip point |
| ot_clear | input | 1 | Die temperature is below the release point |
| boot_above_on | input | 1 | Bootstrap voltage is above the turn-on threshold |
| boot_below_off | input | 1 | Bootstrap voltage is below the turn-off threshold |
| dis_n | input | 1 | External disable request, active low |
| diode_cond | input | 1 | Low-side body diode is conducting |
| gate_hs | output | 1 | High-side gate enable |
| gate_ls | output | 1 | Low-side gate enable |
| pwr_ready | output | 1 | Supply is above the undervoltage level |
| en_drive | output | 1 | Internal enable line |
| aux_reg_en | output | 1 | Auxiliary regulator enable |
| gate_reg_en | output | 1 | Internal gate regulator enable |

## Verification
Shutdown causes (faults, disable, loss of bootstrap) and status outputs reach the ports one edge after they are sampled. A PWM level change first passes through the level register, reaches the switch state one edge later, and then waits out the dead time. A mid-level run acts one edge after its TRI_DLY-th sample. Inputs are driven on falling edges and outputs are read on later falling edges. Gap lengths are measured as counts of both-off samples, so each check compares a cycle count against a dead-time value that the bench tracks arithmetically through up and down sweeps, and against TRI_DLY.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Qualified PWM request handed from the level qualifier to the switch sequencer
  typedef enum logic [1:0] {
    CMD_OFF = 2'd0,
    CMD_LS  = 2'd1,
    CMD_HS  = 2'd2
  } hb_cmd_e;

  // Switch sequencer states
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_GAP  = 2'd1,
    SW_LS   = 2'd2,
    SW_HS   = 2'd3
  } hb_sw_e;

endpackage

// File: rtl/hb_pwm_qual.sv
module hb_pwm_qual
  import hb_pkg::*;
#(
  parameter int unsigned TRI_DLY = 5
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lvl_hi,
  input  logic    lvl_lo,
  output hb_cmd_e cmd
);

  localparam int unsigned CW = $clog2(TRI_DLY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TRI_DLY);

  logic          tri_q, tri_d;
  logic          hi_q, hi_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;
  logic          mid;
  logic          toward_flip;

  always_comb begin
    mid         = !lvl_hi && !lvl_lo;
    toward_flip = tri_q ? !mid : mid;
    cnt_inc     = cnt_q + 1'b1;
    tri_d       = tri_q;
    cnt_d       = '0;
    if (toward_flip) begin
      if (cnt_inc == LIMIT) begin
        tri_d = !tri_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
    // last valid level is held through a mid-window excursion
    hi_d = mid ? hi_q : lvl_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_q <= 1'b0;
      hi_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      tri_q <= tri_d;
      hi_q  <= hi_d;
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    if (tri_q)     cmd = CMD_OFF;
    else if (hi_q) cmd = CMD_HS;
    else           cmd = CMD_LS;
  end

endmodule

// File: rtl/hb_fault_mgr.sv
module hb_fault_mgr (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic ot_trip,
  input  logic ot_clear,
  input  logic dis_n,
  input  logic boot_above_on,
  input  logic boot_below_off,
  output logic run_ok,
  output logic boot_ok,
  output logic pwr_ready,
  output logic en_drive,
  output logic aux_reg_en,
  output logic gate_reg_en
);

  logic ot_q, ot_d;
  logic boot_q;
  logic rdy_d, en_d, aux_d, greg_d;

  always_comb begin
    // thermal latch only operates above the undervoltage level; trip beats clear
    ot_d    = supply_ok ? (ot_trip | (ot_q & ~ot_clear)) : 1'b0;
    boot_ok = boot_above_on | (boot_q & ~boot_below_off);
    run_ok  = supply_ok & dis_n & ~ot_d;
    rdy_d   = supply_ok;
    en_d    = supply_ok & dis_n;
    aux_d   = rdy_d & en_d;
    greg_d  = supply_ok & ~ot_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ot_q        <= 1'b0;
      boot_q      <= 1'b0;
      pwr_ready   <= 1'b0;
      en_drive    <= 1'b0;
      aux_reg_en  <= 1'b0;
      gate_reg_en <= 1'b0;
    end else begin
      ot_q        <= ot_d;
      boot_q      <= boot_ok;
      pwr_ready   <= rdy_d;
      en_drive    <= en_d;
      aux_reg_en  <= aux_d;
      gate_reg_en <= greg_d;
    end
  end

endmodule

// File: rtl/hb_switch_seq.sv
module hb_switch_seq
  import hb_pkg::*;
#(
  parameter int unsigned DT_MIN = 2,
  parameter int unsigned DT_MAX = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run_ok,
  input  hb_cmd_e cmd,
  input  logic    boot_ok,
  input  logic    diode_cond,
  output logic    gate_hs,
  output logic    gate_ls
);

  localparam int unsigned DW = $clog2(DT_MAX + 1);
  localparam logic [DW-1:0] MIN_V = DW'(DT_MIN);
  localparam logic [DW-1:0] MAX_V = DW'(DT_MAX);

  hb_sw_e        st_q, st_d;
  logic [DW-1:0] dt_q, dt_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;
  logic          want_hs, want_ls, seen_now, gap_done;
  logic [DW-1:0] dt_dec, dt_inc;

  always_comb begin
    want_hs  = (cmd == CMD_HS) && boot_ok;
    want_ls  = (cmd == CMD_LS);
    seen_now = seen_q | diode_cond;
    gap_done = (cnt_q >= dt_q - 1'b1);
    dt_dec   = (dt_q > MIN_V) ? dt_q - 1'b1 : MIN_V;
    dt_inc   = (dt_q < MAX_V) ? dt_q + 1'b1 : MAX_V;

    st_d   = st_q;
    dt_d   = dt_q;
    cnt_d  = cnt_q;
    seen_d = seen_q;

    if (!run_ok) begin
      st_d   = SW_IDLE;
      dt_d   = MAX_V;
      cnt_d  = '0;
      seen_d = 1'b0;
    end else begin
      case (st_q)
        SW_IDLE: begin
          st_d   = SW_GAP;
          cnt_d  = '0;
          seen_d = 1'b0;
        end
        SW_GAP: begin
          seen_d = seen_now;
          if (!gap_done) begin
            cnt_d = cnt_q + 1'b1;
          end else if (want_hs || want_ls) begin
            st_d   = want_hs ? SW_HS : SW_LS;
            dt_d   = seen_now ? dt_dec : dt_inc;
            seen_d = 1'b0;
          end
        end
        SW_HS: begin
          if (!want_hs) begin
            st_d   = SW_GAP;
            cnt_d  = '0;
            seen_d = 1'b0;
          end
        end
        default: begin
          if (!want_ls) begin
            st_d   = SW_GAP;
            cnt_d  = '0;
            seen_d = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_IDLE;
      dt_q   <= MAX_V;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dt_q   <= dt_d;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign gate_hs = (st_q == SW_HS);
  assign gate_ls = (st_q == SW_LS);

endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_pkg::*;
#(
  parameter int unsigned TRI_DLY = 5,
  parameter int unsigned DT_MIN  = 2,
  parameter int unsigned DT_MAX  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_above_hi,
  input  logic pwm_below_lo,
  input  logic supply_ok,
  input  logic ot_trip,
  input  logic ot_clear,
  input  logic boot_above_on,
  input  logic boot_below_off,
  input  logic dis_n,
  input  logic diode_cond,
  output logic gate_hs,
  output logic gate_ls,
  output logic pwr_ready,
  output logic en_drive,
  output logic aux_reg_en,
  output logic gate_reg_en
);

  hb_cmd_e cmd;
  logic    run_ok;
  logic    boot_ok;

  hb_pwm_qual #(.TRI_DLY(TRI_DLY)) u_qual (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_hi (pwm_above_hi),
    .lvl_lo (pwm_below_lo),
    .cmd    (cmd)
  );

  hb_fault_mgr u_fault (
    .clk            (clk),
    .rst_n          (rst_n),
    .supply_ok      (supply_ok),
    .ot_trip        (ot_trip),
    .ot_clear       (ot_clear),
    .dis_n          (dis_n),
    .boot_above_on  (boot_above_on),
    .boot_below_off (boot_below_off),
    .run_ok         (run_ok),
    .boot_ok        (boot_ok),
    .pwr_ready      (pwr_ready),
    .en_drive       (en_drive),
    .aux_reg_en     (aux_reg_en),
    .gate_reg_en    (gate_reg_en)
  );

  hb_switch_seq #(.DT_MIN(DT_MIN), .DT_MAX(DT_MAX)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_ok     (run_ok),
    .cmd        (cmd),
    .boot_ok    (boot_ok),
    .diode_cond (diode_cond),
    .gate_hs    (gate_hs),
    .gate_ls    (gate_ls)
  );

endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic ot_trip,
  input logic dis_n,
  input logic boot_above_on,
  input logic boot_below_off,
  input logic gate_hs,
  input logic gate_ls,
  input logic pwr_ready,
  input logic en_drive,
  input logic aux_reg_en,
  input logic gate_reg_en
);

  AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hs && gate_ls)); // R2

  AST_HS_GAP_BEFORE_LS: assert property (@(posedge clk) disable iff (!rst_n)
    gate_hs |=> !gate_ls); // R3

  AST_LS_GAP_BEFORE_HS: assert property (@(posedge clk) disable iff (!rst_n)
    gate_ls |=> !gate_hs); // R3

  AST_FAULT_DROPS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok || !dis_n || ot_trip) |=> (!gate_hs && !gate_ls)); // R7

  AST_UV_STATUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (!pwr_ready && !en_drive && !aux_reg_en && !gate_reg_en)); // R8

  AST_OT_REG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && ot_trip) |=> !gate_reg_en); // R9

  AST_DIS_AUX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n |=> (!aux_reg_en && !en_drive)); // R10

  AST_BOOT_LOW_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_below_off && !boot_above_on) |=> !gate_hs); // R12

endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .supply_ok      (supply_ok),
  .ot_trip        (ot_trip),
  .dis_n          (dis_n),
  .boot_above_on  (boot_above_on),
  .boot_below_off (boot_below_off),
  .gate_hs        (gate_hs),
  .gate_ls        (gate_ls),
  .pwr_ready      (pwr_ready),
  .en_drive       (en_drive),
  .aux_reg_en     (aux_reg_en),
  .gate_reg_en    (gate_reg_en)
);

// File: tb/hb_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hb_gate_ctrl_bench;

  localparam int TRI_DLY = 5;
  localparam int DT_MIN  = 2;
  localparam int DT_MAX  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_above_hi = 1'b0, pwm_below_lo = 1'b0;
  logic supply_ok = 1'b0, ot_trip = 1'b0, ot_clear = 1'b0;
  logic boot_above_on = 1'b0, boot_below_off = 1'b0;
  logic dis_n = 1'b0, diode_cond = 1'b0;
  logic gate_hs, gate_ls, pwr_ready, en_drive, aux_reg_en, gate_reg_en;

  int total = 0;
  int bad = 0;
  int edt;
  int offs;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hb_gate_ctrl #(.TRI_DLY(TRI_DLY), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX)) u_hb_gate_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pwm_above_hi(pwm_above_hi), .pwm_below_lo(pwm_below_lo),
    .supply_ok(supply_ok), .ot_trip(ot_trip), .ot_clear(ot_clear),
    .boot_above_on(boot_above_on), .boot_below_off(boot_below_off),
    .dis_n(dis_n), .diode_cond(diode_cond),
    .gate_hs(gate_hs), .gate_ls(gate_ls), .pwr_ready(pwr_ready),
    .en_drive(en_drive), .aux_reg_en(aux_reg_en), .gate_reg_en(gate_reg_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // 0 = low, 1 = high, 2 = mid window
  task automatic set_pwm(input int lvl);
    pwm_above_hi = (lvl == 1);
    pwm_below_lo = (lvl == 0);
  endtask

  // counts both-off samples until the requested side turns on
  task automatic wait_on(input bit hs, output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (gate_hs && gate_ls) chk("R2 overlap", 1, 0);
      if (hs ? gate_hs : gate_ls) break;
      if (!gate_hs && !gate_ls) n++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    bit side_hs;
    // R1: reset state
    repeat (3) tick();
    chk("R1 gate_hs in reset", gate_hs, 0);
    chk("R1 gate_ls in reset", gate_ls, 0);
    rst_n = 1'b1;
    repeat (2) tick();
    chk("R1 pwr_ready", pwr_ready, 0);
    chk("R1 en_drive", en_drive, 0);
    chk("R1 aux_reg_en", aux_reg_en, 0);
    chk("R1 gate_reg_en", gate_reg_en, 0);
    chk("R1 gates", {30'd0, gate_hs, gate_ls}, 0);

    // R11: first start waits DT_MAX, low level selects low side
    supply_ok = 1'b1; dis_n = 1'b1; boot_above_on = 1'b1; set_pwm(0);
    wait_on(1'b0, offs);
    chk("R11 startup gap", offs, DT_MAX);
    chk("R2 low level hs off", gate_hs, 0);
    chk("R10 aux on when ready and enabled", aux_reg_en, 1);
    chk("R8 pwr_ready up", pwr_ready, 1);
    edt = DT_MAX;
    side_hs = 1'b0;

    // R3 R4: sweep down with diode conduction, then up without
    for (int ph = 0; ph < 2; ph++) begin
      diode_cond = (ph == 0);
      for (int i = 0; i < 10; i++) begin
        repeat (3) tick();
        side_hs = !side_hs;
        set_pwm(side_hs ? 1 : 0);
        wait_on(side_hs, offs);
        chk(ph == 0 ? "R4 gap shrinking" : "R3 gap growing", offs, edt);
        chk("R2 opposite gate off", side_hs ? gate_ls : gate_hs, 0);
        if (ph == 0) edt = (edt > DT_MIN) ? edt - 1 : DT_MIN;
        else         edt = (edt < DT_MAX) ? edt + 1 : DT_MAX;
      end
    end
    diode_cond = 1'b0;
    if (side_hs) begin
      side_hs = 1'b0; set_pwm(0); wait_on(1'b0, offs);
      chk("R3 return to low", offs, edt);
      edt = (edt < DT_MAX) ? edt + 1 : DT_MAX;
    end

    // R5: short mid run is ignored
    repeat (3) tick();
    set_pwm(2);
    for (int i = 0; i < TRI_DLY - 1; i++) begin
      tick();
      chk("R5 short mid keeps ls", gate_ls, 1);
    end
    set_pwm(0);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R5 short mid keeps ls after", gate_ls, 1);
    end
    // R5: long mid run turns off after TRI_DLY samples
    set_pwm(2);
    offs = 0;
    for (int i = 0; i < 50; i++) begin
      tick();
      if (!gate_ls) break;
      offs++;
    end
    chk("R5 mid qualify delay", offs, TRI_DLY);
    repeat (10) tick();
    chk("R5 mid holds off", {30'd0, gate_hs, gate_ls}, 0);
    // R6: short valid run does not resume
    set_pwm(1);
    repeat (TRI_DLY - 1) tick();
    set_pwm(2);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R6 short valid stays off", {30'd0, gate_hs, gate_ls}, 0);
    end
    set_pwm(1);
    wait_on(1'b1, offs);
    chk("R6 resume delay", offs, TRI_DLY);
    edt = (edt < DT_MAX) ? edt + 1 : DT_MAX;

    // R12: bootstrap hysteresis
    repeat (3) tick();
    boot_above_on = 1'b0; boot_below_off = 1'b1;
    tick();
    chk("R12 hs drops on boot low", gate_hs, 0);
    chk("R12 ls stays off", gate_ls, 0);
    boot_below_off = 1'b0;
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R12 not-ready held", gate_hs, 0);
    end
    boot_above_on = 1'b1;
    wait_on(1'b1, offs);
    chk("R12 hs returns at once", offs, 0);
    edt = (edt < DT_MAX) ? edt + 1 : DT_MAX;
    boot_above_on = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R12 ready held", gate_hs, 1);
    end
    boot_above_on = 1'b1;
    side_hs = 1'b1;

    // shrink the dead time before the fault tests
    diode_cond = 1'b1;
    for (int i = 0; i < 3; i++) begin
      repeat (3) tick();
      side_hs = !side_hs;
      set_pwm(side_hs ? 1 : 0);
      wait_on(side_hs, offs);
      chk("R4 shrink before fault", offs, edt);
      edt = (edt > DT_MIN) ? edt - 1 : DT_MIN;
    end
    diode_cond = 1'b0;

    // R7 R9: thermal trip latches
    repeat (3) tick();
    ot_trip = 1'b1;
    tick();
    chk("R7 trip drops gates", {30'd0, gate_hs, gate_ls}, 0);
    chk("R9 gate regulator off", gate_reg_en, 0);
    chk("R10 aux unaffected by trip", aux_reg_en, 1);
    ot_trip = 1'b0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R9 trip latched", {29'd0, gate_reg_en, gate_hs, gate_ls}, 0);
    end
    ot_trip = 1'b1; ot_clear = 1'b1;
    tick();
    chk("R9 trip beats clear", gate_reg_en, 0);
    ot_trip = 1'b0;
    wait_on(side_hs, offs);
    chk("R11 restart after trip uses max", offs, DT_MAX);
    chk("R9 regulator back", gate_reg_en, 1);
    ot_clear = 1'b0;
    edt = DT_MAX;

    // R10 R11: disable request
    diode_cond = 1'b1;
    repeat (3) tick();
    side_hs = !side_hs; set_pwm(side_hs ? 1 : 0);
    wait_on(side_hs, offs);
    chk("R4 one step down", offs, edt);
    diode_cond = 1'b0;
    repeat (3) tick();
    dis_n = 1'b0;
    tick();
    chk("R7 disable drops gates", {30'd0, gate_hs, gate_ls}, 0);
    chk("R10 en_drive low", en_drive, 0);
    chk("R10 aux low", aux_reg_en, 0);
    chk("R10 pwr_ready kept", pwr_ready, 1);
    repeat (4) tick();
    dis_n = 1'b1;
    wait_on(side_hs, offs);
    chk("R11 restart after disable uses max", offs, DT_MAX);
    chk("R10 aux back", aux_reg_en, 1);

    // R8: undervoltage, thermal trip ignored
    repeat (3) tick();
    supply_ok = 1'b0;
    tick();
    chk("R7 uv drops gates", {30'd0, gate_hs, gate_ls}, 0);
    chk("R8 status low in uv", {28'd0, pwr_ready, en_drive, aux_reg_en, gate_reg_en}, 0);
    ot_trip = 1'b1;
    tick();
    ot_trip = 1'b0;
    tick();
    supply_ok = 1'b1;
    wait_on(side_hs, offs);
    chk("R8 trip in uv not kept", offs, DT_MAX);
    chk("R8 regulator on after uv", gate_reg_en, 1);

    finish_run();
  end

endmodule